// File: doc/BRIEF.md
# Audio Control Register Slave

This block is a write-only two-wire serial bus slave. It holds the eight 8-bit control settings of a three-band tone and volume processor. A bus master opens a transfer with a START and sends the device address. It then sends a subaddress byte that names a register and selects between fixed and stepping targets, and then one or more data bytes. The slave pulls the data line low to acknowledge each byte it takes. It places every completed byte into the chosen register, and the register contents are visible at all times on a flat parallel output.

The block samples both bus lines with a fast system clock. Each line passes through a two-flop synchronizer and a stability filter. The system clock must therefore run at roughly ten times the bus clock rate or faster. The acknowledge output is an open-drain pull-down request: a 1 means the data line is driven low.

Top module: `aud_ctl_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. A START in any state, including the middle of a transfer, restarts reception of the address byte. A STOP returns the slave to idle.
- R2: For every byte it accepts, the slave sets `sda_pull_o` to 1 for the ninth clock pulse. At all other times the output is 0.
- R3: In the subaddress byte, bits 3..0 are the register index and bit 4 is the step flag. Bits 7..5 have no effect.
- R4: Only the address byte 0x88 is accepted. Any other address, including 0x89 (read), gets no acknowledge. After such an address the slave acknowledges nothing more and writes nothing until the next START.
- R5: When the step flag is 0, every data byte before the STOP or START is written to the same register.
- R6: When the step flag is 1, the first data byte goes to the selected index and each following byte goes to the next index.
- R7: After reset, the eight registers on `regs_o` (register k at bits 8k+7..8k) hold, for k = 0 to 7: 0x02, 0x0E, 0x38, 0x07, 0x0E, 0x0E, 0x78, 0x78.
- R8: Data bytes aimed at indices 8 to 15 are acknowledged and change no register.
- R9: When stepping, the index wraps from 15 to 0.
- R10: A register is written only when a full byte has arrived, at the rising clock edge of its acknowledge pulse. A byte cut short by a STOP leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least about 10x the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = drive the data line low (acknowledge) |
| regs_o | output | 64 | Eight control registers, register k at bits 8k+7..8k |

## Verification
Each bus line passes through two synchronizer flops and a three-cycle stability filter, plus one edge-detect register. As a result, the acknowledge output and any register write appear about seven system cycles after the bus clock edge that causes them. The bench holds each bus clock phase for 25 system cycles. It samples `sda_pull_o` 25 cycles into the high phase of the ninth clock pulse, well after it has settled. It reads `regs_o` only after the STOP of each transfer, once the final acknowledge pulse has long completed, and compares all eight registers against a model held in the bench.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NREG = 8;
  localparam int unsigned IDXW = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP
  } bus_st_e;

  function automatic logic [DW-1:0] reset_value(int unsigned k);
    case (k)
      0:       reset_value = 8'h02;
      1:       reset_value = 8'h0E;
      2:       reset_value = 8'h38;
      3:       reset_value = 8'h07;
      4:       reset_value = 8'h0E;
      5:       reset_value = 8'h0E;
      default: reset_value = 8'h78;
    endcase
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int unsigned FILT_LEN = 3,
  localparam int unsigned CW = $clog2(FILT_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/bus_engine.sv
module bus_engine
  import aud_ctl_pkg::*;
#(
  parameter logic [DW-1:0] DEV_ADDR = 8'h88
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sda_f_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic            sda_pull_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [DW-1:0]   wr_data_o,
  output bus_st_e         st_o,
  output logic [3:0]      bit_cnt_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  bus_st_e         st_q;
  logic [3:0]      bit_cnt_q;
  logic [DW-1:0]   shift_q;
  logic            ack_q;
  logic [IDXW-1:0] idx_q;
  logic            inc_q;
  logic            active;
  logic            accept;

  assign active = (st_q == ST_ADDR) || (st_q == ST_SUB) || (st_q == ST_DATA);
  assign accept = (st_q != ST_ADDR) || (shift_q == DEV_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      ack_q     <= 1'b0;
      idx_q     <= '0;
      inc_q     <= 1'b0;
    end else if (start_i) begin
      st_q      <= ST_ADDR;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
    end else if (stop_i) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
    end else if (active) begin
      if (scl_rise_i && bit_cnt_q < LAST_BIT) begin
        shift_q   <= {shift_q[DW-2:0], sda_f_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
        ack_q     <= accept;
        bit_cnt_q <= ACK_BIT;
      end else if (scl_fall_i && bit_cnt_q == ACK_BIT) begin
        ack_q     <= 1'b0;
        bit_cnt_q <= '0;
        unique case (st_q)
          ST_ADDR: st_q <= accept ? ST_SUB : ST_SKIP;
          ST_SUB: begin
            st_q  <= ST_DATA;
            idx_q <= shift_q[IDXW-1:0];
            inc_q <= shift_q[IDXW];
          end
          default: if (inc_q) idx_q <= idx_q + 1'b1;
        endcase
      end
    end
  end

  // commit on the rising edge of the acknowledge clock
  assign wr_en_o    = (st_q == ST_DATA) && (bit_cnt_q == ACK_BIT) && scl_rise_i &&
                      (idx_q < IDXW'(NREG)) && !start_i && !stop_i;
  assign wr_idx_o   = idx_q;
  assign wr_data_o  = shift_q;
  assign sda_pull_o = ack_q;
  assign st_o       = st_q;
  assign bit_cnt_o  = bit_cnt_q;
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import aud_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDXW-1:0]    wr_idx_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= reset_value(k);
      else if (wr_en_i && wr_idx_i == IDXW'(k))   q <= wr_data_i;
    end
    assign regs_o[k*DW +: DW] = q;
  end
endmodule

// File: rtl/aud_ctl_slave.sv
module aud_ctl_slave
  import aud_ctl_pkg::*;
#(
  parameter logic [DW-1:0] DEV_ADDR = 8'h88,
  parameter int unsigned   FILT_LEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise_w, scl_fall_w, start_w, stop_w;
  logic            wr_en_w;
  logic [IDXW-1:0] wr_idx_w;
  logic [DW-1:0]   wr_data_w;
  bus_st_e         st_w;
  logic [3:0]      bit_cnt_w;

  line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(scl_i), .out_o(scl_f));
  line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(sda_i), .out_o(sda_f));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise_w = scl_f & ~scl_q;
  assign scl_fall_w = ~scl_f & scl_q;
  assign start_w    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_w     = scl_f & scl_q & ~sda_q & sda_f;

  bus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_f_i(sda_f),
    .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .stop_i(stop_w),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en_w), .wr_idx_o(wr_idx_w),
    .wr_data_o(wr_data_w), .st_o(st_w), .bit_cnt_o(bit_cnt_w));

  reg_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_w),
    .wr_idx_i(wr_idx_w), .wr_data_i(wr_data_w), .regs_o(regs_o));
endmodule

// File: rtl/aud_ctl_checker.sv
module aud_ctl_checker
  import aud_ctl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sda_pull_o,
  input logic [NREG*DW-1:0] regs_o,
  input logic               start_w,
  input logic               stop_w,
  input logic               wr_en_w,
  input bus_st_e            st_w,
  input logic [3:0]         bit_cnt_w
);
  p_start_restarts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (st_w == ST_ADDR && bit_cnt_w == 4'd0));

  p_stop_idles_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (st_w == ST_IDLE && !sda_pull_o));

  p_pull_in_ack_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> bit_cnt_w == 4'd9);

  p_skip_is_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_w == ST_SKIP |-> !sda_pull_o);

  p_regs_only_on_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(wr_en_w));
endmodule

bind aud_ctl_slave aud_ctl_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_pull_o(sda_pull_o), .regs_o(regs_o),
  .start_w(start_w), .stop_w(stop_w), .wr_en_w(wr_en_w),
  .st_w(st_w), .bit_cnt_w(bit_cnt_w));

// File: tb/sim_aud_ctl_slave.sv
module sim_aud_ctl_slave;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_pull;
  logic [63:0] regs;
  wire  sda_line = sda_drv & ~sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_r [8];
  logic ack;

  always #5 clk = ~clk;

  aud_ctl_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs));

  task automatic wq(int n = Q);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int k = 0; k < 8; k++) chk(req, {56'd0, regs[k*8 +: 8]}, {56'd0, exp_r[k]});
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; wq();
    scl = 1'b1;     wq();
    sda_drv = 1'b0; wq();
    scl = 1'b0;     wq();
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wq();
    scl = 1'b1;     wq();
    sda_drv = 1'b1; wq(4 * Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq();
      scl = 1'b1;     wq(2 * Q);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic a);
    send_bits(b, 8);
    sda_drv = 1'b1; wq();
    scl = 1'b1;     wq();
    a = sda_pull;   wq();
    scl = 1'b0;     wq();
  endtask

  task automatic write_seq(logic [7:0] sub, logic [7:0] d [], string req);
    bus_start();
    send_byte(8'h88, ack); chk("R4 addr ack", ack, 1);
    send_byte(sub, ack);   chk("R2 sub ack", ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(req, ack, 1);
    end
    bus_stop();
  endtask

  task automatic t_reset;
    exp_r = '{8'h02, 8'h0E, 8'h38, 8'h07, 8'h0E, 8'h0E, 8'h78, 8'h78};
    chk("R2 idle pull", sda_pull, 0);
    chk_regs("R7 defaults");
  endtask

  task automatic t_single;
    write_seq(8'h02, '{8'h15}, "R2 data ack");
    exp_r[2] = 8'h15;
    chk_regs("R5 single write");
  endtask

  task automatic t_fixed;
    write_seq(8'h03, '{8'h11, 8'h22}, "R5 ack");
    exp_r[3] = 8'h22;
    chk_regs("R5 fixed target");
  endtask

  task automatic t_step;
    write_seq(8'h15, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R8 ack incl idx8");
    exp_r[5] = 8'hA1; exp_r[6] = 8'hB2; exp_r[7] = 8'hC3;
    chk_regs("R6 R8 stepping");
  endtask

  task automatic t_wrap;
    write_seq(8'h1E, '{8'h5A, 8'h6B, 8'h7C}, "R8 ack");
    exp_r[0] = 8'h7C;
    chk_regs("R9 wrap");
  endtask

  task automatic t_bad_addr;
    bus_start();
    send_byte(8'h8A, ack); chk("R4 wrong addr nack", ack, 0);
    send_byte(8'h02, ack); chk("R4 skip nack", ack, 0);
    send_byte(8'h99, ack); chk("R4 skip nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h89, ack); chk("R4 read nack", ack, 0);
    send_byte(8'h01, ack); chk("R4 skip nack", ack, 0);
    bus_stop();
    chk_regs("R4 no write");
  endtask

  task automatic t_partial;
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h01, ack);
    send_bits(8'hA0, 4);
    bus_stop();
    chk_regs("R10 cut byte");
    chk("R10 pull released", sda_pull, 0);
  endtask

  task automatic t_restart;
    bus_start();
    send_byte(8'h88, ack);
    send_byte(8'h04, ack);
    bus_start();
    send_byte(8'h88, ack); chk("R1 restart addr ack", ack, 1);
    send_byte(8'h06, ack);
    send_byte(8'h3C, ack);
    bus_stop();
    exp_r[6] = 8'h3C;
    chk_regs("R1 repeated start");
  endtask

  task automatic t_dont_care;
    write_seq(8'hE1, '{8'h44, 8'h55}, "R3 ack");
    exp_r[1] = 8'h55;
    chk_regs("R3 upper bits ignored");
  endtask

  initial begin
    wq(4);
    rst_n = 1'b1;
    wq(10);
    t_reset();
    t_single();
    t_fixed();
    t_step();
    t_wrap();
    t_bad_addr();
    t_partial();
    t_restart();
    t_dont_care();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule